// File: doc/BRIEF.md
# Bank-Relative Bounds-Checked Access Unit

This unit sits between a stack-machine CPU (plus its I/O channels) and main memory and turns each word access request into a validated memory or register-file operation. A request names an access class, an address, a direction and the requester. The unit picks the bank implied by the class and builds the physical address. It then checks that address against the configured memory size and applies the segment bounds rules that belong to the class and the privilege state. Offsets that fall just above the memory-resident stack top are steered to a small top-of-stack register file.

Each request is accepted in one clock. The result appears on registered outputs on the next clock. The result is one of: a memory access, a top-of-stack register access, both (for write-through), or a single fault flag. The RAM and the register file live outside this block.

Top module: `bank_access_check`

## Requirements
- R1: Class codes on `req_class` are 0 absolute, 1 mapped absolute, 2 fetch, 3 checked fetch, 4 program, 5 checked program, 6 data, 7 checked data, 8 mapped data, 9 checked mapped data, 10 stack, 11 checked stack, 12 DMA. Fetch and program classes use the program bank, data classes use the data bank, stack classes use the stack bank, and the physical address is {bank, req_addr[15:0]}. Absolute, mapped absolute and DMA classes take all of `req_addr` as the physical address; its bits above 15 act as the bank.
- R2: A physical address greater than or equal to `mem_limit` produces no memory or register access. `irq_illegal` is raised only when `req_from_cpu` is 1, and `rd_zero` is raised when the request is a read.
- R3: A write with any fetch or program class (codes 2 to 5) is refused without access and raises `irq_addr_par`.
- R4: A checked fetch read succeeds only when PB <= offset <= PL; otherwise `trap_bounds` is raised whatever the privilege state.
- R5: A checked program read outside PB..PL raises `trap_bounds` unless `priv` is 1, in which case it reads memory.
- R6: Checked data, checked mapped data and checked stack accesses outside DL..SM+SR raise `trap_bounds` unless `priv` is 1.
- R7: For classes 1, 8, 9, 10 and 11, an offset with SM < offset <= SM+SR whose bank equals the stack bank accesses top-of-stack register (SM+SR-offset), computed in 16-bit arithmetic, instead of memory.
- R8: A checked stack or checked mapped-data write that hits a top-of-stack register also writes memory at the same physical address with the same data. The unchecked forms write only the register.
- R9: Classes 0, 2 to 7 and 12 never access the top-of-stack registers.
- R10: Results appear on the outputs exactly one clock after the request. A cycle without a request yields all enables and flags low, and reset clears every output.
- R11: At most one of `irq_illegal`, `trap_bounds` and `irq_addr_par` is high. Priority is illegal address, then address parity on refused writes, then bounds.
- R12: A stack register count `bnd_sr` larger than the register file depth (4) is treated as the depth, both for the register window and for the data bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 4 | Access class code (R1) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_from_cpu | input | 1 | Request issued by the CPU (not a channel) |
| req_addr | input | 20 | Offset in bits 15:0, or full physical address for absolute/DMA |
| req_wdata | input | 16 | Write data |
| bank_prog | input | 4 | Program bank |
| bank_data | input | 4 | Data bank |
| bank_stack | input | 4 | Stack bank |
| bnd_pb | input | 16 | Program base |
| bnd_pl | input | 16 | Program limit |
| bnd_dl | input | 16 | Data limit (lowest data offset) |
| bnd_sm | input | 16 | Memory-resident stack top |
| bnd_sr | input | 3 | Number of stack words held in registers |
| priv | input | 1 | Privileged mode |
| mem_limit | input | 21 | Configured memory size in words |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| mem_en | output | 1 | Memory access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 20 | Memory physical address (zero when no access) |
| tos_en | output | 1 | Top-of-stack register access |
| tos_we | output | 1 | Top-of-stack register write |
| tos_idx | output | 2 | Register index (zero when no access) |
| rsp_wdata | output | 16 | Write data for memory or register |
| rd_zero | output | 1 | Read beyond memory size: return zero |
| irq_illegal | output | 1 | Illegal address interrupt |
| trap_bounds | output | 1 | Bounds violation trap |
| irq_addr_par | output | 1 | Address parity interrupt |

## Verification
On every cycle, the assertions check these invariants: flag exclusivity, silence of the outputs after an illegal or refused access, the one-clock response timing, the absence of register access for classes that are not mapped, the lack of any privilege override for checked fetch, and write-through on checked register hits. The bench's scenarios are what show the concrete address values, register index arithmetic, bank-match gating of the register window, window edges at SM and SM+SR, the privilege override of program and data checks, and the clamping of an oversized SR, because each needs a chosen set of bank and bound values to reveal a wrong answer.

// File: rtl/bac_pkg.sv
package bac_pkg;

  localparam int OFS_W = 16;
  typedef logic [OFS_W-1:0] ofs_t;

  typedef enum logic [3:0] {
    AC_ABS          = 4'd0,
    AC_ABS_MAP      = 4'd1,
    AC_FETCH        = 4'd2,
    AC_FETCH_CHK    = 4'd3,
    AC_PROG         = 4'd4,
    AC_PROG_CHK     = 4'd5,
    AC_DATA         = 4'd6,
    AC_DATA_CHK     = 4'd7,
    AC_DATA_MAP     = 4'd8,
    AC_DATA_MAP_CHK = 4'd9,
    AC_STACK        = 4'd10,
    AC_STACK_CHK    = 4'd11,
    AC_DMA          = 4'd12
  } acc_class_e;

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_PROG  = 2'd1,
    BK_DATA  = 2'd2,
    BK_STACK = 2'd3
  } bank_sel_e;

  function automatic bank_sel_e class_bank(acc_class_e c);
    case (c)
      AC_FETCH, AC_FETCH_CHK, AC_PROG, AC_PROG_CHK:        return BK_PROG;
      AC_DATA, AC_DATA_CHK, AC_DATA_MAP, AC_DATA_MAP_CHK:  return BK_DATA;
      AC_STACK, AC_STACK_CHK:                              return BK_STACK;
      default:                                             return BK_NONE;
    endcase
  endfunction

  // classes that may be served from the top-of-stack registers
  function automatic logic class_maps_tos(acc_class_e c);
    return (c == AC_ABS_MAP) || (c == AC_DATA_MAP) || (c == AC_DATA_MAP_CHK) ||
           (c == AC_STACK) || (c == AC_STACK_CHK);
  endfunction

  // checked mapped classes: register hits on write also reach memory
  function automatic logic class_write_through(acc_class_e c);
    return (c == AC_DATA_MAP_CHK) || (c == AC_STACK_CHK);
  endfunction

  function automatic logic class_code_space(acc_class_e c);
    return (c == AC_FETCH) || (c == AC_FETCH_CHK) || (c == AC_PROG) || (c == AC_PROG_CHK);
  endfunction

  function automatic logic in_window(ofs_t lo, ofs_t hi, ofs_t o);
    return (o >= lo) && (o <= hi);
  endfunction

  // top of the register window, 16-bit wrap-around arithmetic
  function automatic ofs_t window_top(ofs_t sm, ofs_t sr_eff);
    return ofs_t'(sm + sr_eff);
  endfunction

endpackage

// File: rtl/bac_xlate.sv
module bac_xlate
  import bac_pkg::*;
#(
  parameter int BANK_W = 4,
  localparam int PA_W  = BANK_W + OFS_W
) (
  input  acc_class_e         cls,
  input  logic [PA_W-1:0]    req_addr,
  input  logic [BANK_W-1:0]  bank_prog,
  input  logic [BANK_W-1:0]  bank_data,
  input  logic [BANK_W-1:0]  bank_stack,
  input  logic [PA_W:0]      mem_limit,
  output logic [PA_W-1:0]    phys,
  output logic [BANK_W-1:0]  eff_bank,
  output ofs_t               eff_ofs,
  output logic               beyond
);

  always_comb begin
    eff_ofs = req_addr[OFS_W-1:0];
    case (class_bank(cls))
      BK_PROG:  eff_bank = bank_prog;
      BK_DATA:  eff_bank = bank_data;
      BK_STACK: eff_bank = bank_stack;
      default:  eff_bank = req_addr[PA_W-1:OFS_W];
    endcase
    phys   = {eff_bank, eff_ofs};
    beyond = ({1'b0, phys} >= mem_limit);
  end

endmodule

// File: rtl/bac_tos_map.sv
module bac_tos_map
  import bac_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int TOS_DEPTH = 4,
  localparam int IDX_W    = (TOS_DEPTH > 1) ? $clog2(TOS_DEPTH) : 1,
  localparam int SR_W     = $clog2(TOS_DEPTH + 1)
) (
  input  acc_class_e         cls,
  input  logic [BANK_W-1:0]  eff_bank,
  input  logic [BANK_W-1:0]  bank_stack,
  input  ofs_t               eff_ofs,
  input  ofs_t               sm,
  input  logic [SR_W-1:0]    sr,
  output ofs_t               win_top,
  output logic               tos_hit,
  output logic [IDX_W-1:0]   tos_idx
);

  localparam logic [SR_W-1:0] SR_MAX = SR_W'(TOS_DEPTH);

  logic [SR_W-1:0] sr_eff;

  always_comb begin
    sr_eff  = (sr > SR_MAX) ? SR_MAX : sr;
    win_top = window_top(sm, ofs_t'(sr_eff));
    tos_hit = class_maps_tos(cls) && (eff_bank == bank_stack) &&
              (eff_ofs > sm) && (eff_ofs <= win_top);
    tos_idx = IDX_W'(win_top - eff_ofs);
  end

endmodule

// File: rtl/bac_guard.sv
module bac_guard
  import bac_pkg::*;
(
  input  acc_class_e cls,
  input  ofs_t       ofs,
  input  ofs_t       pb,
  input  ofs_t       pl,
  input  ofs_t       dl,
  input  ofs_t       win_top,
  input  logic       priv,
  output logic       range_ok,
  output logic       code_space
);

  always_comb begin
    code_space = class_code_space(cls);
    case (cls)
      AC_FETCH_CHK:                           range_ok = in_window(pb, pl, ofs);
      AC_PROG_CHK:                            range_ok = in_window(pb, pl, ofs) || priv;
      AC_DATA_CHK, AC_DATA_MAP_CHK,
      AC_STACK_CHK:                           range_ok = in_window(dl, win_top, ofs) || priv;
      default:                                range_ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/bank_access_check.sv
module bank_access_check
  import bac_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 16,
  parameter int TOS_DEPTH = 4,
  localparam int PA_W     = BANK_W + OFS_W,
  localparam int IDX_W    = (TOS_DEPTH > 1) ? $clog2(TOS_DEPTH) : 1,
  localparam int SR_W     = $clog2(TOS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_class,
  input  logic              req_write,
  input  logic              req_from_cpu,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BANK_W-1:0] bank_prog,
  input  logic [BANK_W-1:0] bank_data,
  input  logic [BANK_W-1:0] bank_stack,
  input  logic [15:0]       bnd_pb,
  input  logic [15:0]       bnd_pl,
  input  logic [15:0]       bnd_dl,
  input  logic [15:0]       bnd_sm,
  input  logic [SR_W-1:0]   bnd_sr,
  input  logic              priv,
  input  logic [PA_W:0]     mem_limit,
  output logic              rsp_valid,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic              tos_en,
  output logic              tos_we,
  output logic [IDX_W-1:0]  tos_idx,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic              rd_zero,
  output logic              irq_illegal,
  output logic              trap_bounds,
  output logic              irq_addr_par
);

  acc_class_e         cls;
  logic [PA_W-1:0]    phys;
  logic [BANK_W-1:0]  eff_bank;
  ofs_t               eff_ofs;
  ofs_t               win_top;
  logic               beyond;
  logic               tos_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               range_ok;
  logic               code_space;

  assign cls = acc_class_e'(req_class);

  bac_xlate #(.BANK_W(BANK_W)) xlate_i (
    .cls(cls), .req_addr(req_addr), .bank_prog(bank_prog), .bank_data(bank_data),
    .bank_stack(bank_stack), .mem_limit(mem_limit), .phys(phys),
    .eff_bank(eff_bank), .eff_ofs(eff_ofs), .beyond(beyond)
  );

  bac_tos_map #(.BANK_W(BANK_W), .TOS_DEPTH(TOS_DEPTH)) tos_i (
    .cls(cls), .eff_bank(eff_bank), .bank_stack(bank_stack), .eff_ofs(eff_ofs),
    .sm(bnd_sm), .sr(bnd_sr), .win_top(win_top), .tos_hit(tos_hit), .tos_idx(hit_idx)
  );

  bac_guard guard_i (
    .cls(cls), .ofs(eff_ofs), .pb(bnd_pb), .pl(bnd_pl), .dl(bnd_dl),
    .win_top(win_top), .priv(priv), .range_ok(range_ok), .code_space(code_space)
  );

  // next-state decision, priority: illegal > refused write > register hit > bounds
  logic n_mem_en, n_mem_we, n_tos_en, n_tos_we, n_ill, n_bnd, n_par, n_rz;

  always_comb begin
    n_mem_en = 1'b0; n_mem_we = 1'b0; n_tos_en = 1'b0; n_tos_we = 1'b0;
    n_ill    = 1'b0; n_bnd    = 1'b0; n_par    = 1'b0; n_rz     = 1'b0;
    if (req_valid) begin
      if (beyond) begin
        n_ill = req_from_cpu;
        n_rz  = !req_write;
      end else if (req_write && code_space) begin
        n_par = 1'b1;
      end else if (tos_hit) begin
        n_tos_en = 1'b1;
        n_tos_we = req_write;
        if (req_write && class_write_through(cls)) begin
          if (range_ok) begin
            n_mem_en = 1'b1;
            n_mem_we = 1'b1;
          end else begin
            n_bnd = 1'b1;
          end
        end
      end else if (!range_ok) begin
        n_bnd = 1'b1;
      end else begin
        n_mem_en = 1'b1;
        n_mem_we = req_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      mem_en       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      tos_en       <= 1'b0;
      tos_we       <= 1'b0;
      tos_idx      <= '0;
      rsp_wdata    <= '0;
      rd_zero      <= 1'b0;
      irq_illegal  <= 1'b0;
      trap_bounds  <= 1'b0;
      irq_addr_par <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      mem_en       <= n_mem_en;
      mem_we       <= n_mem_we;
      mem_addr     <= n_mem_en ? phys : '0;
      tos_en       <= n_tos_en;
      tos_we       <= n_tos_we;
      tos_idx      <= n_tos_en ? hit_idx : '0;
      rsp_wdata    <= req_wdata;
      rd_zero      <= n_rz;
      irq_illegal  <= n_ill;
      trap_bounds  <= n_bnd;
      irq_addr_par <= n_par;
    end
  end

  // ---------------- assertions ----------------
  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_illegal |-> (!mem_en && !tos_en));

  assert_parity_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_addr_par |-> ($past(req_write) && !mem_en && !tos_en));

  assert_fetch_no_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cls == AC_FETCH_CHK && !req_write && !beyond &&
     (eff_ofs < bnd_pb || eff_ofs > bnd_pl)) |=> trap_bounds);

  assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !beyond && tos_hit && range_ok &&
     (cls == AC_STACK_CHK || cls == AC_DATA_MAP_CHK)) |=> (tos_we && mem_we));

  assert_unmapped_no_tos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(cls == AC_ABS_MAP || cls == AC_DATA_MAP || cls == AC_DATA_MAP_CHK ||
                    cls == AC_STACK || cls == AC_STACK_CHK)) |=> !tos_en);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !mem_en && !tos_en && !irq_illegal && !trap_bounds && !irq_addr_par));

  assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({irq_illegal, trap_bounds, irq_addr_par}) <= 1);

endmodule

// File: tb/bank_access_check_tb_top.sv
`timescale 1ns/1ps
module bank_access_check_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_class = '0;
  logic        req_write = 1'b0;
  logic        req_from_cpu = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  bank_prog = 4'd1, bank_data = 4'd2, bank_stack = 4'd3;
  logic [15:0] bnd_pb = 16'h0100, bnd_pl = 16'h01FF, bnd_dl = 16'h0400, bnd_sm = 16'h0800;
  logic [2:0]  bnd_sr = 3'd3;
  logic        priv = 1'b0;
  logic [20:0] mem_limit = 21'h40000;

  logic        rsp_valid, mem_en, mem_we, tos_en, tos_we, rd_zero;
  logic        irq_illegal, trap_bounds, irq_addr_par;
  logic [19:0] mem_addr;
  logic [1:0]  tos_idx;
  logic [15:0] rsp_wdata;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  bank_access_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_write(req_write), .req_from_cpu(req_from_cpu), .req_addr(req_addr),
    .req_wdata(req_wdata), .bank_prog(bank_prog), .bank_data(bank_data),
    .bank_stack(bank_stack), .bnd_pb(bnd_pb), .bnd_pl(bnd_pl), .bnd_dl(bnd_dl),
    .bnd_sm(bnd_sm), .bnd_sr(bnd_sr), .priv(priv), .mem_limit(mem_limit),
    .rsp_valid(rsp_valid), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .tos_en(tos_en), .tos_we(tos_we), .tos_idx(tos_idx), .rsp_wdata(rsp_wdata),
    .rd_zero(rd_zero), .irq_illegal(irq_illegal), .trap_bounds(trap_bounds),
    .irq_addr_par(irq_addr_par)
  );

  // class codes as stated in R1
  localparam logic [3:0] C_ABS = 0, C_ABSM = 1, C_FCH = 2, C_FCHK = 3, C_PRG = 4, C_PRGK = 5,
                         C_DAT = 6, C_DATK = 7, C_DMAP = 8, C_DMAPK = 9, C_STK = 10,
                         C_STKK = 11, C_DMA = 12;

  // expected response bundle: {mem_en, mem_we, mem_addr, tos_en, tos_we, tos_idx, ill, bnd, par, rd_zero}
  function automatic logic [30:0] bundle(logic me, logic mw, logic [19:0] ma, logic te, logic tw,
                                         logic [1:0] ti, logic il, logic bd, logic pa, logic rz);
    return {me, mw, ma, te, tw, ti, il, bd, pa, rz};
  endfunction

  function automatic logic [30:0] mem_rd(logic [19:0] a);  return bundle(1,0,a,0,0,0,0,0,0,0); endfunction
  function automatic logic [30:0] mem_wr(logic [19:0] a);  return bundle(1,1,a,0,0,0,0,0,0,0); endfunction
  function automatic logic [30:0] tos_rd(logic [1:0] i);   return bundle(0,0,0,1,0,i,0,0,0,0); endfunction
  function automatic logic [30:0] bnd_tr();                return bundle(0,0,0,0,0,0,0,1,0,0); endfunction

  task automatic issue(input logic [3:0] c, input logic w, input logic [19:0] a, input logic cpu);
    @(negedge clk);
    req_valid = 1'b1; req_class = c; req_write = w; req_addr = a; req_from_cpu = cpu;
    req_wdata = a[15:0] ^ 16'h5A5A;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rsp(input string tag, input logic [30:0] exp_b);
    logic [30:0] act_b;
    act_b = {mem_en, mem_we, mem_addr, tos_en, tos_we, tos_idx,
             irq_illegal, trap_bounds, irq_addr_par, rd_zero};
    total++;
    if (act_b !== exp_b || rsp_valid !== 1'b1) begin
      bad++;
      $display("FAIL %s: actual=%h valid=%b expected=%h valid=1", tag, act_b, rsp_valid, exp_b);
    end
  endtask

  task automatic t_reset();
    total++;
    if ({rsp_valid, mem_en, tos_en, irq_illegal, trap_bounds, irq_addr_par, rd_zero} !== 7'b0) begin
      bad++;
      $display("FAIL R10 reset: actual=%b expected=0", {rsp_valid, mem_en, tos_en, irq_illegal,
               trap_bounds, irq_addr_par, rd_zero});
    end
  endtask

  task automatic t_translate();
    issue(C_DAT, 0, 20'h01234, 1); expect_rsp("R1 data bank", mem_rd(20'h21234));
    issue(C_PRG, 0, 20'hF0050, 1); expect_rsp("R1 program bank ignores high bits", mem_rd(20'h10050));
    issue(C_ABS, 0, 20'h3ABCD, 1); expect_rsp("R1 absolute", mem_rd(20'h3ABCD));
    issue(C_DMA, 1, 20'h00010, 0); expect_rsp("R1 dma write", mem_wr(20'h00010));
    total++;
    if (rsp_wdata !== (16'h0010 ^ 16'h5A5A)) begin
      bad++; $display("FAIL R1 wdata: actual=%h expected=%h", rsp_wdata, 16'h0010 ^ 16'h5A5A);
    end
  endtask

  task automatic t_limit();
    bank_data = 4'd5;
    issue(C_DAT, 0, 20'h00001, 1); expect_rsp("R2 cpu read beyond", bundle(0,0,0,0,0,0,1,0,0,1));
    issue(C_DAT, 1, 20'h00001, 1); expect_rsp("R2 cpu write beyond", bundle(0,0,0,0,0,0,1,0,0,0));
    bank_data = 4'd2;
    issue(C_DMA, 0, 20'h40000, 0); expect_rsp("R2 channel read at limit", bundle(0,0,0,0,0,0,0,0,0,1));
    issue(C_ABS, 0, 20'h3FFFF, 1); expect_rsp("R2 last word", mem_rd(20'h3FFFF));
  endtask

  task automatic t_code_write();
    issue(C_PRG, 1, 20'h00150, 1);  expect_rsp("R3 program write", bundle(0,0,0,0,0,0,0,0,1,0));
    issue(C_FCHK, 1, 20'h00150, 1); expect_rsp("R3 checked fetch write", bundle(0,0,0,0,0,0,0,0,1,0));
    issue(C_PRGK, 1, 20'h00900, 1); expect_rsp("R3 over bounds R11", bundle(0,0,0,0,0,0,0,0,1,0));
    bank_prog = 4'd7;
    issue(C_FCH, 1, 20'h00150, 1);  expect_rsp("R11 illegal over parity", bundle(0,0,0,0,0,0,1,0,0,0));
    bank_prog = 4'd1;
  endtask

  task automatic t_fetch();
    issue(C_FCHK, 0, 20'h00100, 1); expect_rsp("R4 at PB", mem_rd(20'h10100));
    issue(C_FCHK, 0, 20'h001FF, 1); expect_rsp("R4 at PL", mem_rd(20'h101FF));
    issue(C_FCHK, 0, 20'h00200, 1); expect_rsp("R4 above PL", bnd_tr());
    issue(C_FCHK, 0, 20'h000FF, 1); expect_rsp("R4 below PB", bnd_tr());
    priv = 1'b1;
    issue(C_FCHK, 0, 20'h00200, 1); expect_rsp("R4 privileged still traps", bnd_tr());
    priv = 1'b0;
  endtask

  task automatic t_program();
    issue(C_PRGK, 0, 20'h00200, 1); expect_rsp("R5 user out of range", bnd_tr());
    priv = 1'b1;
    issue(C_PRGK, 0, 20'h00200, 1); expect_rsp("R5 privileged override", mem_rd(20'h10200));
    priv = 1'b0;
  endtask

  task automatic t_data_bounds();
    issue(C_DATK, 0, 20'h00400, 1); expect_rsp("R6 at DL", mem_rd(20'h20400));
    issue(C_DATK, 0, 20'h003FF, 1); expect_rsp("R6 below DL", bnd_tr());
    issue(C_DATK, 0, 20'h00803, 1); expect_rsp("R6 at SM+SR", mem_rd(20'h20803));
    issue(C_DATK, 0, 20'h00804, 1); expect_rsp("R6 above SM+SR", bnd_tr());
    issue(C_STKK, 1, 20'h00804, 1); expect_rsp("R6 stack write above", bnd_tr());
    priv = 1'b1;
    issue(C_DATK, 0, 20'h00804, 1); expect_rsp("R6 privileged", mem_rd(20'h20804));
    priv = 1'b0;
  endtask

  task automatic t_tos_map();
    issue(C_STK, 0, 20'h00801, 1);  expect_rsp("R7 stack idx2", tos_rd(2'd2));
    issue(C_STK, 0, 20'h00803, 1);  expect_rsp("R7 stack idx0", tos_rd(2'd0));
    issue(C_STK, 0, 20'h00800, 1);  expect_rsp("R7 at SM goes to memory", mem_rd(20'h30800));
    issue(C_DMAP, 0, 20'h00802, 1); expect_rsp("R7 mapped data other bank", mem_rd(20'h20802));
    bank_data = 4'd3;
    issue(C_DMAP, 0, 20'h00802, 1); expect_rsp("R7 mapped data stack bank", tos_rd(2'd1));
    issue(C_ABSM, 0, 20'h30801, 1); expect_rsp("R7 mapped absolute hit", tos_rd(2'd2));
    issue(C_ABSM, 0, 20'h20801, 1); expect_rsp("R7 mapped absolute miss", mem_rd(20'h20801));
    issue(C_STKK, 0, 20'h00802, 1); expect_rsp("R7 checked stack read", tos_rd(2'd1));
    bank_data = 4'd2;
  endtask

  task automatic t_write_through();
    issue(C_STKK, 1, 20'h00802, 1); expect_rsp("R8 checked stack write", bundle(1,1,20'h30802,1,1,2'd1,0,0,0,0));
    issue(C_STK, 1, 20'h00802, 1);  expect_rsp("R8 unchecked stack write", bundle(0,0,0,1,1,2'd1,0,0,0,0));
    bank_data = 4'd3;
    issue(C_DMAPK, 1, 20'h00803, 1); expect_rsp("R8 checked mapped data write", bundle(1,1,20'h30803,1,1,2'd0,0,0,0,0));
    bank_data = 4'd2;
  endtask

  task automatic t_unmapped();
    bank_data = 4'd3;
    issue(C_DAT, 0, 20'h00802, 1);  expect_rsp("R9 data read", mem_rd(20'h30802));
    issue(C_DATK, 1, 20'h00802, 1); expect_rsp("R9 checked data write", mem_wr(20'h30802));
    bank_data = 4'd2;
    issue(C_ABS, 0, 20'h30802, 1);  expect_rsp("R9 absolute", mem_rd(20'h30802));
    issue(C_DMA, 1, 20'h30801, 0);  expect_rsp("R9 dma", mem_wr(20'h30801));
  endtask

  task automatic t_sr_clamp();
    bnd_sr = 3'd7;
    issue(C_STK, 0, 20'h00804, 1);  expect_rsp("R12 top clamps to depth", tos_rd(2'd0));
    issue(C_STK, 0, 20'h00801, 1);  expect_rsp("R12 deepest register", tos_rd(2'd3));
    issue(C_STK, 0, 20'h00805, 1);  expect_rsp("R12 beyond clamped window", mem_rd(20'h30805));
    issue(C_STKK, 0, 20'h00805, 1); expect_rsp("R12 clamped bound", bnd_tr());
    bnd_sr = 3'd3;
  endtask

  task automatic t_idle();
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    total++;
    if ({rsp_valid, mem_en, tos_en, irq_illegal, trap_bounds, irq_addr_par} !== 6'b0) begin
      bad++;
      $display("FAIL R10 idle: actual=%b expected=0",
               {rsp_valid, mem_en, tos_en, irq_illegal, trap_bounds, irq_addr_par});
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_translate();
    t_limit();
    t_code_write();
    t_fetch();
    t_program();
    t_data_bounds();
    t_tos_map();
    t_write_through();
    t_unmapped();
    t_sr_clamp();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule